// File: doc/BRIEF.md
# Two-Client Return-to-Zero Resource Arbiter

This block lets two clients share one resource. Each client and the resource talk to the arbiter through a request/grant pair. Every exchange is a four-phase, return-to-zero handshake: the request rises, the grant rises, the request falls, and then the grant falls. Requests from the clients and the grant from the resource are treated as asynchronous. Each one crosses a multi-stage synchronizer before the logic acts on it, and all decisions are then made on one system clock.

A mutual-exclusion stage picks the client that asked first. The winner's request is passed on as the single resource request line. The resource's grant is steered back to the winner and to no one else. The winner keeps its grant until the resource drops its own grant. A client that is waiting is not forwarded until the previous resource handshake has returned to zero. If both requests show up in the same sampling cycle, the first such tie goes to client 1, and later ties alternate between the clients. The resource-side pair has the same shape as a client-side pair, so one instance can feed a client port of the next instance to build a tree for more clients.

Top module: `rtz_pair_arbiter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, and right after that edge, `c1_gnt`, `c2_gnt` and `res_req` are 0. This also holds when reset hits in the middle of a granted handshake.
- R2: With `SYNC_STAGES` = 2 and the arbiter idle, `res_req` goes high at the third rising edge that sees a client request high. It is still low after the second such edge.
- R3: A lone request from one client is served. That client's grant rises at the third rising edge that sees `res_gnt` high. Under random traffic, every request from either client is granted.
- R4: `c1_gnt` and `c2_gnt` are never both high.
- R5: If one client's request is sampled one or more cycles before the other's, the earlier client gets the grant first.
- R6: When both requests are first sampled in the same cycle, the first such tie goes to client 1. Each later tie goes to the other client than the previous tie did.
- R7: A client grant rises only while `res_req` is high, and only for the winning client. The losing client's grant stays low for the whole handshake.
- R8: The winner's grant stays high after the winner drops its request, for as long as `res_gnt` is high. It falls at the third rising edge that sees `res_gnt` low.
- R9: While the resource still holds `res_gnt` high from the previous handshake, `res_req` stays low, even if the other client is waiting. `res_req` rises only when both client grants are low.
- R10: Once `res_req` is raised, it stays high until a client grant is given. It falls only after the winner has lowered its request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| c1_req | input | 1 | Client 1 request, asynchronous |
| c1_gnt | output | 1 | Client 1 grant |
| c2_req | input | 1 | Client 2 request, asynchronous |
| c2_gnt | output | 1 | Client 2 grant |
| res_req | output | 1 | Merged request to the shared resource |
| res_gnt | input | 1 | Grant from the shared resource, asynchronous |

## Verification
The checker runs every cycle on the ordering rules that need no history beyond one edge. These are: grant exclusion, a grant rising only under a live resource request, a grant falling only after the resource request has dropped, a new resource request starting only with both grants clear, and an ungranted resource request being held. Exact latencies through the synchronizers, first-come ordering, the alternating tie rule and reset in mid-handshake depend on when the requests arrive. Only the bench's directed scenarios can show those. Random traffic, with a resource that answers at varying delays, shows that no request is lost or starved.

// File: rtl/rtz_arb_pkg.sv
// Shared types for the two-client return-to-zero arbiter.
// Assumes: exactly two clients and one resource.
package rtz_arb_pkg;

    // Handshake sequencing states toward the resource.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,   // no handshake open, resource grant low
        ST_ASK   = 2'd1,   // resource request high, waiting for its grant
        ST_HOLD  = 2'd2,   // winner granted, waiting for its request to fall
        ST_DRAIN = 2'd3    // resource request low, waiting for its grant to fall
    } arb_state_t;

    // Identity of a client chosen by the mutual-exclusion stage.
    typedef enum logic {
        PICK_C1 = 1'b0,
        PICK_C2 = 1'b1
    } pick_t;

endpackage

// File: rtl/rtz_sync.sv
// Multi-stage synchronizer, one chain per bit.
// Assumes: inputs are asynchronous, level signals that hold for longer
// than STAGES clock periods. Resets to all zero.
module rtz_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // first flop: capture the raw inputs
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= d;
            end
        end else begin : g_next
            // later flops: pass on the previous stage
            always_ff @(posedge clk) begin
                if (!rst_n) chain[s] <= '0;
                else        chain[s] <= chain[s-1];
            end
        end
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/rtz_mutex.sv
// Mutual-exclusion decision between two synchronized client requests.
// Picks whichever client is requesting. On a tie it uses a rotating
// pointer that starts at client 1 and flips each time a tie is committed.
// Assumes: 'take' is high only in the cycle the sequencer accepts the pick.
module rtz_mutex
    import rtz_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req_s,      // bit 0 = client 1, bit 1 = client 2
    input  logic       take,
    output logic       pick_valid,
    output pick_t      pick
);
    pick_t tie_next;
    logic  both;

    assign both = req_s[0] & req_s[1];

    // combinational choice: a lone requester wins, a tie follows the pointer
    always_comb begin
        pick_valid = req_s[0] | req_s[1];
        if (both)          pick = tie_next;
        else if (req_s[1]) pick = PICK_C2;
        else               pick = PICK_C1;
    end

    // tie pointer: flips only when a tied decision is committed
    always_ff @(posedge clk) begin
        if (!rst_n)            tie_next <= PICK_C1;
        else if (take && both) tie_next <= (tie_next == PICK_C1) ? PICK_C2 : PICK_C1;
    end

endmodule

// File: rtl/rtz_seq.sv
// Four-phase sequencer toward the resource, with grant steering.
// Opens a resource handshake for the picked client, returns the resource
// grant to that client only, and holds the grant until the resource's
// grant has returned to zero.
// Assumes: the inputs are already synchronized, and all parties follow
// the four-phase order.
module rtz_seq
    import rtz_arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] req_s,      // bit 0 = client 1, bit 1 = client 2
    input  logic       rgnt_s,
    input  logic       pick_valid,
    input  pick_t      pick,
    output logic       take,
    output logic       res_req,
    output logic [1:0] cgnt        // bit 0 = client 1, bit 1 = client 2
);
    arb_state_t state;
    pick_t      owner;
    logic       owner_req;

    // accept a decision only when idle and the old resource grant is gone
    assign take = (state == ST_IDLE) && pick_valid && !rgnt_s;

    // request level of the current owner
    assign owner_req = (owner == PICK_C2) ? req_s[1] : req_s[0];

    // handshake sequencing and registered grant steering
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            owner   <= PICK_C1;
            res_req <= 1'b0;
            cgnt    <= 2'b00;
        end else begin
            case (state)
                ST_IDLE: if (take) begin
                    owner   <= pick;
                    res_req <= 1'b1;
                    state   <= ST_ASK;
                end
                ST_ASK: if (rgnt_s) begin
                    cgnt  <= (owner == PICK_C2) ? 2'b10 : 2'b01;
                    state <= ST_HOLD;
                end
                ST_HOLD: if (!owner_req) begin
                    res_req <= 1'b0;
                    state   <= ST_DRAIN;
                end
                ST_DRAIN: if (!rgnt_s) begin
                    cgnt  <= 2'b00;
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/rtz_pair_arbiter.sv
// Two-client resource arbiter with four-phase handshakes on every port.
// Synchronizes the three asynchronous inputs, decides between clients
// with a mutual-exclusion stage, and sequences one resource handshake at
// a time. The resource side has the same shape as a client pair, so
// instances can be stacked into a tree.
// Assumes: SYNC_STAGES >= 2.
module rtz_pair_arbiter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic c1_req,
    output logic c1_gnt,
    input  logic c2_req,
    output logic c2_gnt,
    output logic res_req,
    input  logic res_gnt
);
    import rtz_arb_pkg::*;

    localparam int N_CLIENTS = 2;
    localparam int SYNC_W    = N_CLIENTS + 1;

    logic [SYNC_W-1:0]    raw_in;
    logic [SYNC_W-1:0]    sync_out;
    logic [N_CLIENTS-1:0] req_s;
    logic [N_CLIENTS-1:0] cgnt;
    logic                 rgnt_s;
    logic                 take;
    logic                 pick_valid;
    pick_t                pick;

    assign raw_in = {res_gnt, c2_req, c1_req};
    assign req_s  = sync_out[N_CLIENTS-1:0];
    assign rgnt_s = sync_out[N_CLIENTS];

    rtz_sync #(
        .WIDTH  (SYNC_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (raw_in),
        .q     (sync_out)
    );

    rtz_mutex u_mutex (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_s      (req_s),
        .take       (take),
        .pick_valid (pick_valid),
        .pick       (pick)
    );

    rtz_seq u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_s      (req_s),
        .rgnt_s     (rgnt_s),
        .pick_valid (pick_valid),
        .pick       (pick),
        .take       (take),
        .res_req    (res_req),
        .cgnt       (cgnt)
    );

    assign c1_gnt = cgnt[0];
    assign c2_gnt = cgnt[1];

endmodule

// File: rtl/rtz_pair_arbiter_chk.sv
// Protocol checker for rtz_pair_arbiter. It watches only the ports.
module rtz_pair_arbiter_chk (
    input logic clk,
    input logic rst_n,
    input logic c1_gnt,
    input logic c2_gnt,
    input logic res_req,
    input logic res_gnt
);
    AST_GNT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(c1_gnt && c2_gnt)); // R4
    AST_GNT_UNDER_RREQ: assert property (@(posedge clk) disable iff (!rst_n) ($rose(c1_gnt) || $rose(c2_gnt)) |-> res_req); // R7
    AST_GNT_FALL_AFTER_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) ($fell(c1_gnt) || $fell(c2_gnt)) |-> !res_req); // R8
    AST_RREQ_AFTER_RTZ: assert property (@(posedge clk) disable iff (!rst_n) $rose(res_req) |-> (!c1_gnt && !c2_gnt)); // R9
    AST_RREQ_HELD: assert property (@(posedge clk) disable iff (!rst_n) (res_req && !c1_gnt && !c2_gnt) |=> res_req); // R10
endmodule

bind rtz_pair_arbiter rtz_pair_arbiter_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .c1_gnt  (c1_gnt),
    .c2_gnt  (c2_gnt),
    .res_req (res_req),
    .res_gnt (res_gnt)
);

// File: tb/rtz_pair_arbiter_test.sv
module rtz_pair_arbiter_test;
    localparam int WATCHDOG = 150000;
    localparam int ROUNDS   = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:1] creq = 2'b00;
    logic [2:1] cgnt;
    logic       res_req;
    logic       res_gnt = 1'b0;
    logic       res_auto = 1'b0;
    logic       mon_on = 1'b0;
    int         n_chk = 0;
    int         n_bad = 0;
    int         cycles = 0;
    int         served [2:1];
    bit         done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    rtz_pair_arbiter uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .c1_req  (creq[1]),
        .c1_gnt  (cgnt[1]),
        .c2_req  (creq[2]),
        .c2_gnt  (cgnt[2]),
        .res_req (res_req),
        .res_gnt (res_gnt)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // expected winner of the n-th tie (counting from zero)
    function automatic int tie_expect(input int n);
        return (n % 2 == 0) ? 1 : 2;
    endfunction

    function automatic int other(input int who);
        return (who == 1) ? 2 : 1;
    endfunction

    task automatic wait_rreq(input logic val, input int maxc, input string tag);
        int n = 0;
        while (res_req !== val && n < maxc) begin step(); n++; end
        if (res_req !== val) chk(0, tag, int'(res_req), int'(val));
    endtask

    task automatic wait_gnt(input int who, input logic val, input int maxc, input string tag);
        int n = 0;
        while (cgnt[who] !== val && n < maxc) begin step(); n++; end
        if (cgnt[who] !== val) chk(0, tag, int'(cgnt[who]), int'(val));
    endtask

    // Manual resource handshake; 'who' is the client expected to win.
    task automatic txn(input int who, input string tag);
        int n = 0;
        wait_rreq(1'b1, 20, "R10 resource request raised");
        res_gnt = 1'b1;
        while (cgnt == 2'b00 && n < 10) begin step(); n++; end
        chk(cgnt == (who == 1 ? 2'b01 : 2'b10), tag, int'(cgnt), (who == 1) ? 1 : 2);   // R7 winner only
        creq[who] = 1'b0;
        wait_rreq(1'b0, 10, "R10 resource request released");
        chk(cgnt[who] == 1'b1, "R8 grant held after request drop", int'(cgnt[who]), 1);
        for (int i = 0; i < 3; i++) begin
            step();
            chk(cgnt[who] == 1'b1, "R8 grant held while resource grant high", int'(cgnt[who]), 1);
            chk(res_req == 1'b0, "R9 no new resource request before return to zero", int'(res_req), 0);
        end
        res_gnt = 1'b0;
        step(); step();
        chk(cgnt[who] == 1'b1, "R8 grant still high before sync", int'(cgnt[who]), 1);
        step();
        chk(cgnt == 2'b00, "R8 grant released", int'(cgnt), 0);
    endtask

    // Automatic resource responder with random latency.
    initial begin
        forever begin
            step();
            if (res_auto) begin
                if (res_req && !res_gnt) begin
                    repeat ($urandom_range(0, 3)) step();
                    res_gnt = 1'b1;
                end else if (!res_req && res_gnt) begin
                    repeat ($urandom_range(0, 3)) step();
                    res_gnt = 1'b0;
                end
            end
        end
    end

    // Exclusion monitor during random traffic (R4).
    initial begin
        forever begin
            step();
            if (mon_on) chk(!(cgnt[1] && cgnt[2]), "R4 both grants high", int'(cgnt), 0);
        end
    end

    // Watchdog.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > WATCHDOG && !done) begin
                chk(0, "watchdog expired", cycles, WATCHDOG);
                summary();
            end
        end
    end

    task automatic client_loop(input int who);
        for (int r = 0; r < ROUNDS; r++) begin
            repeat ($urandom_range(0, 6)) step();
            creq[who] = 1'b1;
            wait_gnt(who, 1'b1, 400, "R3 random request granted");
            chk(cgnt[other(who)] == 1'b0, "R7 loser grant low", int'(cgnt[other(who)]), 0);
            repeat ($urandom_range(0, 4)) step();
            creq[who] = 1'b0;
            wait_gnt(who, 1'b0, 400, "R8 random grant released");
            served[who]++;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        served[1] = 0;
        served[2] = 0;

        // R1: reset state
        repeat (4) step();
        chk(cgnt == 2'b00 && res_req == 1'b0, "R1 reset outputs", int'({cgnt, res_req}), 0);
        rst_n = 1'b1;
        step();

        // R2 and R3: exact latencies for a lone client 1 request
        creq[1] = 1'b1;
        step(); step();
        chk(res_req == 1'b0, "R2 resource request not yet raised", int'(res_req), 0);
        step();
        chk(res_req == 1'b1, "R2 resource request after three edges", int'(res_req), 1);
        res_gnt = 1'b1;
        step(); step();
        chk(cgnt == 2'b00, "R3 grant not yet given", int'(cgnt), 0);
        step();
        chk(cgnt == 2'b01, "R3 client 1 granted after three edges", int'(cgnt), 1);
        txn(1, "R3 lone client 1 served");

        // R3: lone client 2
        repeat (3) step();
        creq[2] = 1'b1;
        txn(2, "R3 lone client 2 served");

        // R5: client 2 first, client 1 two cycles later; R9 gating of client 1
        repeat (3) step();
        creq[2] = 1'b1;
        step(); step();
        creq[1] = 1'b1;
        txn(2, "R5 earlier client 2 wins");
        txn(1, "R5 later client 1 served next");

        // R5: client 1 first by one cycle
        repeat (3) step();
        creq[1] = 1'b1;
        step();
        creq[2] = 1'b1;
        txn(1, "R5 earlier client 1 wins");
        txn(2, "R5 later client 2 served next");

        // R6: three ties in a row alternate
        for (int t = 0; t < 3; t++) begin
            repeat (3) step();
            creq = 2'b11;
            txn(tie_expect(t), "R6 tie winner");
            txn(other(tie_expect(t)), "R6 tie loser served next");
        end

        // R3, R4, R7: random traffic with an automatic resource
        res_auto = 1'b1;
        mon_on = 1'b1;
        fork
            client_loop(1);
            client_loop(2);
        join
        mon_on = 1'b0;
        chk(served[1] == ROUNDS, "R3 all client 1 requests served", served[1], ROUNDS);
        chk(served[2] == ROUNDS, "R3 all client 2 requests served", served[2], ROUNDS);
        wait_rreq(1'b0, 20, "R10 idle after random traffic");
        repeat (10) step();
        res_auto = 1'b0;
        res_gnt = 1'b0;
        repeat (5) step();

        // R1: reset in the middle of a granted handshake
        creq[1] = 1'b1;
        wait_rreq(1'b1, 20, "R10 request before reset");
        res_gnt = 1'b1;
        wait_gnt(1, 1'b1, 20, "R3 grant before reset");
        rst_n = 1'b0;
        step();
        chk(cgnt == 2'b00 && res_req == 1'b0, "R1 reset mid-handshake", int'({cgnt, res_req}), 0);
        creq[1] = 1'b0;
        res_gnt = 1'b0;
        step();
        rst_n = 1'b1;
        repeat (5) step();
        chk(cgnt == 2'b00 && res_req == 1'b0, "R1 quiet after reset", int'({cgnt, res_req}), 0);

        done = 1'b1;
        summary();
    end

endmodule